// File: doc/BRIEF.md
# USB Host Interface Power-Up Sequencer

This block brings an external USB host interface chip from power-on into host mode by issuing a fixed series of register accesses through a simple request/acknowledge register port. The port itself, which turns each access into serial traffic, sits outside the block. The sequencer first sets up the chip's pin behaviour. It then pulses the chip's internal reset by writing the reset bit and clearing it again. Next it reads the chip's interrupt status until the oscillator reports stable, with a bounded number of reads. Finally it selects host mode with both data-line pull-downs, enables the interrupt pin and enables the connect, frame and bus-event host interrupts.

A one-cycle `start_i` pulse launches the sequence. When the final write is acknowledged, `done_o` pulses for one cycle. At that point `timeout_o` shows whether the oscillator poll ran out of attempts, and `remaining_o` holds the number of attempts left. A timed-out poll does not cut the sequence short: the three closing writes are still issued.

Top module: `usbh_pwrup_seq`

## Requirements
- R1: During and after a synchronous active-low reset, `req_o`, `done_o` and `timeout_o` are 0 and `remaining_o` is 0.
- R2: A `start_i` pulse while idle begins the sequence; the first access is a write of 0x18 to register address 17.
- R3: The second and third accesses are writes to address 15, first of 0x20 and then of 0x00.
- R4: The fourth phase reads address 13 (`write_o`=0). A read value is accepted when, with bits 6 and 5 cleared, it equals exactly 0x01. For example, 0x61 and 0x21 are accepted, while 0x00, 0x03, 0x81 and 0x02 are rejected and cause another read.
- R5: The attempt counter is loaded with POLL_LIMIT (1024) at start and decremented once per rejected read; at `done_o`, `remaining_o` equals POLL_LIMIT minus the number of rejected reads.
- R6: After POLL_LIMIT rejected reads the poll stops, `timeout_o` reads 1 and `remaining_o` reads 0 at `done_o`, and the closing writes of R7 are still issued.
- R7: After the poll, the sequence writes 0xC1 to address 27, then 0x01 to address 16, then 0x61 to address 26, and issues no further access.
- R8: `req_o` stays high with stable `addr_o`, `write_o` and `wdata_o` until a cycle in which `ack_i` is high; in the following cycle `req_o` is low.
- R9: `done_o` is a single-cycle pulse in the cycle after the last acknowledge; `timeout_o` and `remaining_o` keep their final values until the next accepted start, and `timeout_o` is cleared on that start.
- R10: A `start_i` pulse while a sequence is running is ignored: the access order is unchanged and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| req_o | output | 1 | Register access request, held until acknowledged |
| write_o | output | 1 | 1 for a write access, 0 for a read |
| addr_o | output | 5 | Register address of the access |
| wdata_o | output | 8 | Write data of the access |
| ack_i | input | 1 | Access complete; read data valid in this cycle |
| rdata_i | input | 8 | Read data returned with `ack_i` |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| timeout_o | output | 1 | Oscillator poll exhausted its attempts |
| remaining_o | output | 11 | Poll attempts left when the sequence ended |

## Verification
The hardest case to reach from the ports is the exhausted poll. Reaching it needs the full 1024 rejected reads, after which the three closing writes must still appear in order. The bench gets there with a responder that returns a rejecting default whenever its table of poll answers is empty, and with a scoreboard that expects 1024 consecutive reads of the status address. The masking rule is exercised by a table mixing values whose only set bits are the ignored VBUS positions with values that differ from the accepted one outside them. A second start pulse lands while an acknowledge is being held off.

// File: rtl/usbh_pwrup_pkg.sv
// Shared definitions for the USB host interface power-up sequencer.
// Assumes a 5-bit register address space and 8-bit registers on the chip.
package usbh_pwrup_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 8;

    // Register addresses used by the sequence
    localparam logic [REG_AW-1:0] A_PIN_CFG   = 5'd17;
    localparam logic [REG_AW-1:0] A_USB_CTRL  = 5'd15;
    localparam logic [REG_AW-1:0] A_USB_STAT  = 5'd13;
    localparam logic [REG_AW-1:0] A_OP_MODE   = 5'd27;
    localparam logic [REG_AW-1:0] A_CPU_CFG   = 5'd16;
    localparam logic [REG_AW-1:0] A_HOST_IRQEN = 5'd26;

    // Values written
    localparam logic [REG_DW-1:0] V_PIN_CFG   = 8'h18; // level irq, full-duplex serial
    localparam logic [REG_DW-1:0] V_RST_ON    = 8'h20;
    localparam logic [REG_DW-1:0] V_RST_OFF   = 8'h00;
    localparam logic [REG_DW-1:0] V_OP_MODE   = 8'hC1; // host, both pull-downs
    localparam logic [REG_DW-1:0] V_CPU_CFG   = 8'h01; // interrupt pin on
    localparam logic [REG_DW-1:0] V_HOST_IRQEN = 8'h61; // connect, frame, bus event

    // Oscillator readiness rule
    localparam logic [REG_DW-1:0] OSC_IGNORE = 8'h60;
    localparam logic [REG_DW-1:0] OSC_READY  = 8'h01;

    typedef enum logic [2:0] {
        ST_PIN_CFG,
        ST_RST_ON,
        ST_RST_OFF,
        ST_OSC_POLL,
        ST_OP_MODE,
        ST_CPU_CFG,
        ST_HOST_IRQEN
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_REQ,
        PH_GAP
    } phase_e;

endpackage

// File: rtl/usbh_pwrup_step_rom.sv
// Maps a sequence step to the register access it issues.
// Assumes steps are visited in enum order; pure combinational decode.
module usbh_pwrup_step_rom
    import usbh_pwrup_pkg::*;
(
    input  step_e              step_i,
    output logic [REG_AW-1:0]  addr_o,
    output logic [REG_DW-1:0]  wdata_o,
    output logic               is_read_o,
    output logic               is_last_o
);

    // Decode the access for the current step
    always_comb begin
        addr_o    = A_PIN_CFG;
        wdata_o   = V_PIN_CFG;
        is_read_o = 1'b0;
        is_last_o = 1'b0;
        unique case (step_i)
            ST_PIN_CFG:    begin addr_o = A_PIN_CFG;    wdata_o = V_PIN_CFG;    end
            ST_RST_ON:     begin addr_o = A_USB_CTRL;   wdata_o = V_RST_ON;     end
            ST_RST_OFF:    begin addr_o = A_USB_CTRL;   wdata_o = V_RST_OFF;    end
            ST_OSC_POLL:   begin addr_o = A_USB_STAT;   wdata_o = '0; is_read_o = 1'b1; end
            ST_OP_MODE:    begin addr_o = A_OP_MODE;    wdata_o = V_OP_MODE;    end
            ST_CPU_CFG:    begin addr_o = A_CPU_CFG;    wdata_o = V_CPU_CFG;    end
            ST_HOST_IRQEN: begin addr_o = A_HOST_IRQEN; wdata_o = V_HOST_IRQEN; is_last_o = 1'b1; end
            default:       begin addr_o = A_PIN_CFG;    wdata_o = V_PIN_CFG;    end
        endcase
    end

endmodule

// File: rtl/usbh_pwrup_osc_check.sv
// Decides whether a status read reports a stable oscillator.
// Assumes the VBUS bits carry no meaning for readiness and are ignored.
module usbh_pwrup_osc_check
    import usbh_pwrup_pkg::*;
(
    input  logic [REG_DW-1:0] status_i,
    output logic              ready_o
);

    // Compare the masked status with the single ready bit
    always_comb begin
        ready_o = ((status_i & ~OSC_IGNORE) == OSC_READY);
    end

endmodule

// File: rtl/usbh_pwrup_poll_ctr.sv
// Down-counter of remaining oscillator poll attempts.
// Assumes LIMIT >= 1; load has priority over decrement.
module usbh_pwrup_poll_ctr #(
    parameter int LIMIT = 1024,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          dec_i,
    output logic [CW-1:0] count_o,
    output logic          at_one_o
);

    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);
    localparam logic [CW-1:0] ONE_V   = CW'(1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down per rejected read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LIMIT_V;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE_V;
        end
    end

    assign count_o  = cnt_q;
    assign at_one_o = (cnt_q == ONE_V);

endmodule

// File: rtl/usbh_pwrup_seq.sv
// Power-up sequencer for a USB host interface chip.
// Issues a fixed series of register accesses over a request/acknowledge
// port, each held until acknowledged and followed by one idle cycle.
// Assumes ack_i is only meaningful while req_o is high.
module usbh_pwrup_seq
    import usbh_pwrup_pkg::*;
#(
    parameter int POLL_LIMIT = 1024,
    parameter int CW         = $clog2(POLL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              req_o,
    output logic              write_o,
    output logic [REG_AW-1:0] addr_o,
    output logic [REG_DW-1:0] wdata_o,
    input  logic              ack_i,
    input  logic [REG_DW-1:0] rdata_i,
    output logic              done_o,
    output logic              timeout_o,
    output logic [CW-1:0]     remaining_o
);

    phase_e phase_q;
    step_e  step_q;
    logic   done_q;
    logic   tmo_q;

    logic   is_read;
    logic   is_last;
    logic   osc_ok;
    logic   at_one;
    logic   accept;
    logic   load_cnt;
    logic   dec_cnt;
    logic   poll_fail;

    usbh_pwrup_step_rom u_rom (
        .step_i    (step_q),
        .addr_o    (addr_o),
        .wdata_o   (wdata_o),
        .is_read_o (is_read),
        .is_last_o (is_last)
    );

    usbh_pwrup_osc_check u_osc (
        .status_i (rdata_i),
        .ready_o  (osc_ok)
    );

    usbh_pwrup_poll_ctr #(
        .LIMIT (POLL_LIMIT),
        .CW    (CW)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_cnt),
        .dec_i    (dec_cnt),
        .count_o  (remaining_o),
        .at_one_o (at_one)
    );

    // Decode the handshake events of the current cycle
    always_comb begin
        accept    = (phase_q == PH_REQ) && ack_i;
        load_cnt  = (phase_q == PH_IDLE) && start_i;
        dec_cnt   = accept && is_read && !osc_ok;
        poll_fail = dec_cnt && at_one;
    end

    // Advance phase and step, raise done and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_PIN_CFG;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_REQ;
                        step_q  <= ST_PIN_CFG;
                        tmo_q   <= 1'b0;
                    end
                end
                PH_REQ: begin
                    if (accept) begin
                        if (is_last) begin
                            done_q  <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_GAP;
                            if (!is_read || osc_ok || at_one) begin
                                step_q <= step_e'(step_q + 3'd1);
                            end
                            if (poll_fail) begin
                                tmo_q <= 1'b1;
                            end
                        end
                    end
                end
                PH_GAP: begin
                    phase_q <= PH_REQ;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign req_o     = (phase_q == PH_REQ);
    assign write_o   = !is_read;
    assign done_o    = done_q;
    assign timeout_o = tmo_q;

endmodule

// File: rtl/usbh_pwrup_seq_chk.sv
// Protocol and result checks for the power-up sequencer, bound to its top.
module usbh_pwrup_seq_chk
    import usbh_pwrup_pkg::*;
#(
    parameter int CW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_o,
    input logic              write_o,
    input logic [REG_AW-1:0] addr_o,
    input logic [REG_DW-1:0] wdata_o,
    input logic              ack_i,
    input logic              done_o,
    input logic              timeout_o,
    input logic [CW-1:0]     remaining_o
);

    // R1: reset forces quiet outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!req_o && !done_o && !timeout_o && remaining_o == '0));

    // R8: request held stable until acknowledged
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(write_o) && $stable(wdata_o)));

    // R8: one idle cycle after each acknowledge
    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

    // R4: every read targets the status register
    a_r4_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !write_o) |-> (addr_o == A_USB_STAT));

    // R9: done lasts one cycle and never overlaps a request
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_o);

    // R6: timeout implies no attempts left
    a_r6_tmo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> (remaining_o == '0));

endmodule

bind usbh_pwrup_seq usbh_pwrup_seq_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_o       (req_o),
    .write_o     (write_o),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .ack_i       (ack_i),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .remaining_o (remaining_o)
);

// File: tb/tb_usbh_pwrup_seq.sv
`timescale 1ns/1ps
module tb_usbh_pwrup_seq;

    localparam int LIMIT = 1024;
    localparam int CW    = $clog2(LIMIT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          req_o;
    logic          write_o;
    logic [4:0]    addr_o;
    logic [7:0]    wdata_o;
    logic          ack_i = 1'b0;
    logic [7:0]    rdata_i = 8'h00;
    logic          done_o;
    logic          timeout_o;
    logic [CW-1:0] remaining_o;

    always #2.5 clk = ~clk;

    usbh_pwrup_seq #(.POLL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_o(req_o), .write_o(write_o), .addr_o(addr_o), .wdata_o(wdata_o),
        .ack_i(ack_i), .rdata_i(rdata_i),
        .done_o(done_o), .timeout_o(timeout_o), .remaining_o(remaining_o)
    );

    typedef struct packed {
        logic       wr;
        logic [4:0] addr;
        logic [7:0] data;
    } txn_t;

    txn_t       exp_q[$];
    logic [7:0] poll_q[$];
    logic [7:0] poll_dflt = 8'h00;
    int         lat = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: expected accesses
    task automatic push_w(input logic [4:0] a, input logic [7:0] d);
        txn_t t;
        t.wr = 1'b1; t.addr = a; t.data = d;
        exp_q.push_back(t);
    endtask

    task automatic push_reads(input int n);
        for (int i = 0; i < n; i++) begin
            txn_t t;
            t.wr = 1'b0; t.addr = 5'd13; t.data = 8'h00;
            exp_q.push_back(t);
        end
    endtask

    task automatic push_seq(input int nreads);
        push_w(5'd17, 8'h18);   // R2
        push_w(5'd15, 8'h20);   // R3
        push_w(5'd15, 8'h00);   // R3
        push_reads(nreads);     // R4
        push_w(5'd27, 8'hC1);   // R7
        push_w(5'd16, 8'h01);   // R7
        push_w(5'd26, 8'h61);   // R7
    endtask

    // monitor / responder: pop, compare, acknowledge
    bit         pending = 0;
    int         wcnt = 0;
    logic [4:0] cap_a;
    logic [7:0] cap_d;
    logic       cap_w;

    always @(negedge clk) begin
        if (!rst_n) begin
            ack_i   = 1'b0;
            pending = 0;
        end else if (ack_i) begin
            ack_i   = 1'b0;
            pending = 0;
        end else if (req_o && !pending) begin
            txn_t  e;
            string tag;
            cap_a = addr_o; cap_d = wdata_o; cap_w = write_o;
            tag = (addr_o == 5'd17) ? "R2" : (addr_o == 5'd15) ? "R3" :
                  (addr_o == 5'd13) ? "R4" : "R7";
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected access", int'(addr_o), -1);
            end else begin
                e = exp_q.pop_front();
                chk(e.wr == write_o && e.addr == addr_o && (!e.wr || e.data == wdata_o),
                    tag, int'({write_o, addr_o, wdata_o}), int'({e.wr, e.addr, (e.wr ? e.data : wdata_o)}));
            end
            if (!write_o) rdata_i = (poll_q.size() > 0) ? poll_q.pop_front() : poll_dflt;
            pending = 1;
            wcnt = lat;
            if (wcnt == 0) ack_i = 1'b1;
        end else if (pending) begin
            chk(req_o && addr_o == cap_a && wdata_o == cap_d && write_o == cap_w,
                "R8 hold", int'({req_o, addr_o}), int'({1'b1, cap_a}));
            wcnt--;
            if (wcnt <= 0) ack_i = 1'b1;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic run_seq(input int exp_rem, input bit exp_tmo, input bit extra_start);
        int guard = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(timeout_o == 1'b0, "R9 timeout cleared on start", int'(timeout_o), 0);
        if (extra_start) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;   // R10: must be ignored
        end
        while (!done_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_o == 1'b1, "R9 done seen", int'(done_o), 1);
        chk(int'(remaining_o) == exp_rem, "R5 remaining", int'(remaining_o), exp_rem);
        chk(timeout_o == exp_tmo, "R6 timeout flag", int'(timeout_o), int'(exp_tmo));
        chk(exp_q.size() == 0, "R7 all accesses issued", exp_q.size(), 0);
        chk(poll_q.size() == 0, "R4 all poll answers used", poll_q.size(), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", int'(done_o), 0);
        chk(timeout_o == exp_tmo && int'(remaining_o) == exp_rem, "R9 results held",
            int'(remaining_o), exp_rem);
        repeat (5) @(negedge clk);
        chk(req_o == 1'b0, "R10 no further sequence", int'(req_o), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_o == 0 && done_o == 0 && timeout_o == 0 && remaining_o == '0,
            "R1 reset outputs", int'({req_o, done_o, timeout_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_o == 0 && done_o == 0, "R1 idle after reset", int'({req_o, done_o}), 0);

        // ready on first read
        lat = 0;
        poll_q = '{8'h01};
        push_seq(1);
        run_seq(LIMIT, 1'b0, 1'b0);

        // masked values: 0x61 accepted after four rejects; held acknowledge; stray start
        lat = 3;
        poll_q = '{8'h00, 8'h03, 8'h81, 8'h02, 8'h61};
        push_seq(5);
        run_seq(LIMIT - 4, 1'b0, 1'b1);

        // 0x21 accepted after one reject
        lat = 1;
        poll_q = '{8'h40, 8'h21};
        push_seq(2);
        run_seq(LIMIT - 1, 1'b0, 1'b0);

        // exhausted poll
        lat = 0;
        poll_dflt = 8'h00;
        push_seq(LIMIT);
        run_seq(0, 1'b1, 1'b0);

        // timeout cleared by a new sequence
        poll_q = '{8'h41};
        push_seq(1);
        run_seq(LIMIT, 1'b0, 1'b0);

        finish_run();
    end

endmodule